// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block turns the filtered input levels of a 32-line GPIO bank into interrupt requests. Each line has its own configuration: an enable, a choice between edge and level sensing, a sense (rising or active-high against falling or active-low), an override that catches both edges whatever the sense, and a mask. From these the block keeps two vectors. The raw vector shows what detection has found. The visible vector is the raw vector with the masked lines removed. One request output is the OR of the visible vector.

Edge events are held in a per-line latch until software writes a 1 to that line's bit of the end-of-interrupt vector. Level events are not latched: they follow the pin. Edges are found by comparing each input with a registered copy of its value from the previous cycle. The first sample after reset is not compared against the reset value, so a line that is already high leaves reset without a false edge. Register decoding is done elsewhere. The configuration and the end-of-interrupt pulse vector arrive here as plain signals.

Top module: `gpio_irq_detect`

## Requirements
- R1: During reset and after it, with no event yet seen, `raw_status_o`, `status_o` and `irq_o` are all zero.
- R2: An enabled line with `edge_mode_i`=1, `polarity_i`=1 and `dual_edge_i`=0 sets its raw bit on a 0-to-1 input change. A 1-to-0 change does not set it.
- R3: An enabled line with `edge_mode_i`=1, `polarity_i`=0 and `dual_edge_i`=0 sets its raw bit on a 1-to-0 change. A 0-to-1 change does not set it.
- R4: An enabled edge line with `dual_edge_i`=1 sets its raw bit on either change, for either value of `polarity_i`.
- R5: A latched edge bit stays set after the pin returns. It clears only in the cycle after its `eoi_i` bit is 1. `eoi_i` bits of other lines have no effect on it.
- R6: If a new qualifying edge and the `eoi_i` bit for that line are sampled in the same cycle, the raw bit stays set.
- R7: An enabled line with `edge_mode_i`=0 has its raw bit equal to (pin == `polarity_i`), with a delay of one cycle. `eoi_i` does not affect it.
- R8: A line with `line_en_i`=0 has raw bit 0. A latched edge on it is discarded, so re-enabling it does not bring the old event back.
- R9: `status_o` equals `raw_status_o` AND NOT the mask sampled in the same cycle. Masked lines keep detecting into `raw_status_o`.
- R10: `irq_o` is 1 exactly when some bit of `status_o` is 1.
- R11: Every output is registered from the inputs sampled at one rising clock edge and changes right after that edge. The first input sample after reset produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Filtered input level of each line |
| line_en_i | input | 32 | Per-line detection enable |
| edge_mode_i | input | 32 | 1 selects edge sensing, 0 level sensing |
| polarity_i | input | 32 | 1 selects rising/high, 0 selects falling/low |
| dual_edge_i | input | 32 | 1 catches both edges and ignores polarity |
| mask_i | input | 32 | 1 hides the line from status and request |
| eoi_i | input | 32 | Single-cycle pulse vector; 1 clears the line's edge latch |
| raw_status_o | output | 32 | Detected events before masking |
| status_o | output | 32 | Detected events after masking |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every result is due one cycle after the stimulus that causes it. This holds for an edge, a level, a mask change and an end-of-interrupt pulse alike: the effect is visible just after the rising edge that samples the changed input. The bench changes inputs one time unit after a rising edge. A behavioural model takes the same samples and advances once per edge. The outputs are compared with it one time unit after every edge, so each result is checked in the cycle it is due. Directed checks at known steps cover the corner cases. A long stretch of random stimulus follows them.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    parameter int unsigned GPIO_LINES = 32;

    typedef logic [GPIO_LINES-1:0] line_vec_t;

    // Registered state of the detector.
    typedef struct packed {
        line_vec_t prev;    // input level seen at the previous edge
        line_vec_t latch;   // held edge events
        line_vec_t raw;     // events before masking
        line_vec_t status;  // events after masking
        logic      armed;   // a previous sample exists
        logic      irq;     // combined request
    } det_state_t;

endpackage

// File: rtl/gpio_irq_edges.sv
module gpio_irq_edges
    import gpio_irq_pkg::*;
(
    input  line_vec_t pin_i,
    input  line_vec_t prev_i,
    input  logic      armed_i,
    output line_vec_t rise_o,
    output line_vec_t fall_o
);

    line_vec_t armed_vec;

    assign armed_vec = {GPIO_LINES{armed_i}};
    assign rise_o    = pin_i & ~prev_i & armed_vec;
    assign fall_o    = ~pin_i & prev_i & armed_vec;

endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line (
    input  logic pin_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic en_i,
    input  logic edge_mode_i,
    input  logic polarity_i,
    input  logic dual_edge_i,
    input  logic eoi_i,
    input  logic latch_q_i,
    output logic latch_d_o,
    output logic level_d_o
);

    logic sensed_edge;
    logic edge_active;

    always_comb begin
        if (dual_edge_i) begin
            sensed_edge = rise_i | fall_i;
        end else if (polarity_i) begin
            sensed_edge = rise_i;
        end else begin
            sensed_edge = fall_i;
        end
        edge_active = en_i & edge_mode_i;
        // A fresh edge wins over a clear in the same cycle.
        latch_d_o   = edge_active & ((latch_q_i & ~eoi_i) | sensed_edge);
        level_d_o   = en_i & ~edge_mode_i & (pin_i == polarity_i);
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t pin_i,
    input  line_vec_t line_en_i,
    input  line_vec_t edge_mode_i,
    input  line_vec_t polarity_i,
    input  line_vec_t dual_edge_i,
    input  line_vec_t mask_i,
    input  line_vec_t eoi_i,
    output line_vec_t raw_status_o,
    output line_vec_t status_o,
    output logic      irq_o
);

    det_state_t st_d, st_q;
    line_vec_t  rise_w, fall_w;
    line_vec_t  latch_nx, level_nx;

    gpio_irq_edges u_edges (
        .pin_i   (pin_i),
        .prev_i  (st_q.prev),
        .armed_i (st_q.armed),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    for (genvar gi = 0; gi < GPIO_LINES; gi++) begin : g_line
        gpio_irq_line u_line (
            .pin_i       (pin_i[gi]),
            .rise_i      (rise_w[gi]),
            .fall_i      (fall_w[gi]),
            .en_i        (line_en_i[gi]),
            .edge_mode_i (edge_mode_i[gi]),
            .polarity_i  (polarity_i[gi]),
            .dual_edge_i (dual_edge_i[gi]),
            .eoi_i       (eoi_i[gi]),
            .latch_q_i   (st_q.latch[gi]),
            .latch_d_o   (latch_nx[gi]),
            .level_d_o   (level_nx[gi])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.prev   = pin_i;
        st_d.armed  = 1'b1;
        st_d.latch  = latch_nx;
        st_d.raw    = latch_nx | level_nx;
        st_d.status = st_d.raw & ~mask_i;
        st_d.irq    = |st_d.status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_status_o = st_q.raw;
    assign status_o     = st_q.status;
    assign irq_o        = st_q.irq;

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
    import gpio_irq_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input line_vec_t line_en_i,
    input line_vec_t edge_mode_i,
    input line_vec_t mask_i,
    input line_vec_t eoi_i,
    input line_vec_t raw_status_o,
    input line_vec_t status_o,
    input logic      irq_o
);

    // R9: visible events are the raw events less the mask of the same sample
    assert_masked_view_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status_o == (raw_status_o & ~$past(mask_i)));

    // R10: request tracks any visible event
    assert_irq_any_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (status_o != '0));

    // R8: a disabled line reports nothing
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_status_o & ~$past(line_en_i)) == '0);

    // R5: a held edge event survives while its line stays enabled, edge-type and not cleared
    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(raw_status_o & line_en_i & edge_mode_i & ~eoi_i) & $past(edge_mode_i, 2))
         & ~raw_status_o) == '0);

endmodule

bind gpio_irq_detect gpio_irq_detect_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_en_i    (line_en_i),
    .edge_mode_i  (edge_mode_i),
    .mask_i       (mask_i),
    .eoi_i        (eoi_i),
    .raw_status_o (raw_status_o),
    .status_o     (status_o),
    .irq_o        (irq_o)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
    import gpio_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic      clk = 1'b0;
    logic      rst_n = 1'b0;
    line_vec_t pin = '0, en = '0, edm = '0, pol = '0, dual = '0, msk = '0, eoi = '0;
    line_vec_t raw_o, stat_o;
    logic      irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit m_prev[GPIO_LINES];
    bit m_latch[GPIO_LINES];
    bit m_armed;
    line_vec_t m_raw, m_stat;
    bit m_irq;

    gpio_irq_detect uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .line_en_i(en), .edge_mode_i(edm),
        .polarity_i(pol), .dual_edge_i(dual), .mask_i(msk), .eoi_i(eoi),
        .raw_status_o(raw_o), .status_o(stat_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_vec(string req, string what, line_vec_t got, line_vec_t exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_bit(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < GPIO_LINES; i++) begin
            m_prev[i]  = 0;
            m_latch[i] = 0;
        end
        m_armed = 0; m_raw = '0; m_stat = '0; m_irq = 0;
    endtask

    task automatic model_step();
        bit r, f, hit, lvl;
        for (int i = 0; i < GPIO_LINES; i++) begin
            r = m_armed && pin[i] && !m_prev[i];
            f = m_armed && !pin[i] && m_prev[i];
            if (dual[i]) hit = r || f;
            else if (pol[i]) hit = r;
            else hit = f;
            if (!(en[i] && edm[i])) m_latch[i] = 0;
            else if (hit) m_latch[i] = 1;
            else if (eoi[i]) m_latch[i] = 0;
            lvl = en[i] && !edm[i] && (pin[i] == pol[i]);
            m_raw[i]  = m_latch[i] || lvl;
            m_stat[i] = m_raw[i] && !msk[i];
            m_prev[i] = pin[i];
        end
        m_armed = 1;
        m_irq = (m_stat != '0);
    endtask

    // one clock: model follows the edge, outputs compared just after it (R11)
    task automatic step();
        @(posedge clk);
        #1;
        model_step();
        check_vec("R11", "raw vs model", raw_o, m_raw);
        check_vec("R11", "status vs model", stat_o, m_stat);
        check_bit("R11", "irq vs model", irq_o, m_irq);
    endtask

    task automatic pulse_eoi(line_vec_t v);
        eoi = v;
        step();
        eoi = '0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        en   = 32'h0000_FFFF;         // lines 16..31 disabled
        edm  = 32'h0000_00FF;         // lines 0..7 edge, 8..15 level
        pol  = 32'h0000_FF05;         // line0,2 rising; 8..15 active high
        dual = 32'h0000_000C;         // lines 2,3 both edges
        pin  = 32'h0000_0001;         // line0 already high in reset
        repeat (3) @(posedge clk);
        #1;
        check_vec("R1", "raw in reset", raw_o, '0);
        check_vec("R1", "status in reset", stat_o, '0);
        check_bit("R1", "irq in reset", irq_o, 1'b0);
        rst_n = 1'b1;

        step();
        check_bit("R11", "no edge from reset value line0", raw_o[0], 1'b0);
        check_vec("R1", "raw idle after reset", raw_o, '0);

        pin[0] = 0; step();
        check_bit("R2", "falling ignored on rising line", raw_o[0], 1'b0);
        pin[0] = 1; step();
        check_bit("R2", "rising latched", raw_o[0], 1'b1);
        pin[0] = 0; step();
        check_bit("R5", "held after pin returns", raw_o[0], 1'b1);
        pulse_eoi(32'h0000_0002);
        check_bit("R5", "other eoi bit no effect", raw_o[0], 1'b1);
        pulse_eoi(32'h0000_0001);
        check_bit("R5", "cleared by eoi", raw_o[0], 1'b0);

        pin[1] = 1; step();
        check_bit("R3", "rising ignored on falling line", raw_o[1], 1'b0);
        pin[1] = 0; step();
        check_bit("R3", "falling latched", raw_o[1], 1'b1);
        pulse_eoi(32'h0000_0002);

        pin[2] = 1; step();
        check_bit("R4", "dual rising", raw_o[2], 1'b1);
        pulse_eoi(32'h0000_0004);
        pin[2] = 0; step();
        check_bit("R4", "dual falling", raw_o[2], 1'b1);
        pin[3] = 1; step();
        check_bit("R4", "dual rising with polarity 0", raw_o[3], 1'b1);
        pulse_eoi(32'h0000_000C);
        check_vec("R5", "dual latches cleared", raw_o & 32'hF, '0);

        pin[0] = 1; eoi = 32'h0000_0001; step(); eoi = '0;
        check_bit("R6", "edge beats same-cycle eoi", raw_o[0], 1'b1);
        pulse_eoi(32'h0000_0001);

        pin[8] = 1; step();
        check_bit("R7", "level high seen", raw_o[8], 1'b1);
        pulse_eoi(32'h0000_0100);
        check_bit("R7", "eoi leaves level bit", raw_o[8], 1'b1);
        pin[8] = 0; step();
        check_bit("R7", "level follows pin low", raw_o[8], 1'b0);

        pin[20] = 1; step();
        pin[20] = 0; step();
        check_bit("R8", "disabled line silent", raw_o[20], 1'b0);
        pin[4] = 1; step();
        pin[4] = 0; step();
        check_bit("R3", "line4 falling latched", raw_o[4], 1'b1);
        en[4] = 0; step();
        check_bit("R8", "disable drops latch", raw_o[4], 1'b0);
        en[4] = 1; step();
        check_bit("R8", "re-enable no stale event", raw_o[4], 1'b0);

        msk = 32'h0000_0004;
        pin[2] = 1; step();
        check_bit("R9", "masked line still detects", raw_o[2], 1'b1);
        check_bit("R9", "masked line hidden", stat_o[2], 1'b0);
        check_bit("R10", "no request while masked", irq_o, 1'b0);
        msk = '0; step();
        check_bit("R9", "unmask shows event", stat_o[2], 1'b1);
        check_bit("R10", "request on unmask", irq_o, 1'b1);
        pulse_eoi(32'h0000_0004);
        check_bit("R10", "request drops after clear", irq_o, 1'b0);

        for (int n = 0; n < 2000; n++) begin
            if (n % 16 == 0) begin
                en   = $urandom;
                edm  = $urandom;
                pol  = $urandom;
                dual = $urandom & $urandom;
            end
            if (n % 8 == 0) msk = $urandom;
            pin = pin ^ ($urandom & $urandom & $urandom);
            eoi = $urandom & $urandom;
            step();
        end
        eoi = '0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule